// File: doc/BRIEF.md
# DMA Interrupt Control and Status Register

This block is the combined interrupt control and status word of a multi-channel DMA engine. Software writes the word over a simple register bus and can read it back at any time. The word holds a small configuration field, one interrupt enable per channel, a master enable and a bus-error flag. It also holds one completion flag per channel and a summary flag. Each DMA channel reports the end of a transfer with a single-cycle pulse. That pulse latches the channel's completion flag, but only when the channel's enable is set.

After every update the block decides whether an interrupt is pending. It is pending when the master enable is set and any completion flag is set, or when the bus-error flag is set. The decision is stored in the summary bit. When the summary bit goes from clear to set, the block sends one single-cycle request to the system interrupt controller on that controller's status line 3. No further request follows while the summary bit stays set. The request is armed again only after the condition has gone away, which clears the summary bit.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x00000000 and irq_o is low.
- R2: A write loads bits 5:0, bit 15 (bus error) and bits 23:16 (bit 16+n = channel n enable, bit 23 = master enable) directly from the written data. Bits 14:6 always read zero.
- R3: Completion flags in bits 30:24 (bit 24+n = channel n) are write-one-to-clear. A written 1 clears the flag, a written 0 leaves it unchanged, and a write can never set a flag.
- R4: A pulse on done_i[n] sets flag 24+n only if enable bit 16+n holds after any write in the same cycle. If the same cycle also writes a 1 to clear that flag, the flag ends up set.
- R5: After every update, bit 31 is set when (bit 23 and any of bits 30:24) or bit 15 is true, and is cleared otherwise.
- R6: irq_o is high for exactly one cycle, in the cycle after an update that sets bit 31 while it was clear.
- R7: No further irq_o pulse occurs while bit 31 stays set. Once bit 31 has been cleared, the next activation raises irq_o again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| done_i | input | NUM_CH | Per-channel transfer-complete pulses |
| rd_data_o | output | 32 | Current register value |
| irq_o | output | 1 | One-cycle request to interrupt controller status bit 3 |

## Verification
Every result is registered once. A write or completion pulse applied before a clock edge shows up in rd_data_o after that edge, and the irq_o pulse belonging to that update appears in the same cycle and is gone one cycle later. The bench drives inputs on the falling edge and then advances a behavioural model by one update. Before driving the next inputs, it compares both outputs against the model on the following falling edge, so each comparison lands exactly one clock after its stimulus.

// File: rtl/dicr_pkg.sv
package dicr_pkg;
  localparam int REG_W      = 32;
  localparam int MAX_CH     = 7;
  localparam int CFG_W      = 6;
  localparam int BUSERR_BIT = 15;
  localparam int EN_LSB     = 16;
  localparam int MASTER_BIT = 23;
  localparam int FLAG_LSB   = 24;
  localparam int SENT_BIT   = 31;
endpackage

// File: rtl/dicr_wr_merge.sv
module dicr_wr_merge
  import dicr_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic [REG_W-1:0]  cur_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic [REG_W-1:0]  nxt_o
);
  logic [REG_W-1:0]  after_wr;
  logic [MAX_CH-1:0] set_ch;

  always_comb begin
    after_wr = cur_i;
    after_wr[SENT_BIT] = 1'b0;
    if (wr_en_i) begin
      after_wr[CFG_W-1:0]                = wr_data_i[CFG_W-1:0];
      after_wr[BUSERR_BIT]               = wr_data_i[BUSERR_BIT];
      after_wr[MASTER_BIT:EN_LSB]        = wr_data_i[MASTER_BIT:EN_LSB];
      after_wr[FLAG_LSB+MAX_CH-1:FLAG_LSB] =
        cur_i[FLAG_LSB+MAX_CH-1:FLAG_LSB] & ~wr_data_i[FLAG_LSB+MAX_CH-1:FLAG_LSB];
    end
  end

  // enable seen after same-cycle write; set beats clear
  for (genvar n = 0; n < MAX_CH; n++) begin : g_ch
    if (n < NUM_CH) begin : g_used
      assign set_ch[n] = done_i[n] & after_wr[EN_LSB+n];
    end else begin : g_unused
      assign set_ch[n] = 1'b0;
    end
  end

  always_comb begin
    nxt_o = after_wr;
    nxt_o[FLAG_LSB+MAX_CH-1:FLAG_LSB] = after_wr[FLAG_LSB+MAX_CH-1:FLAG_LSB] | set_ch;
  end
endmodule

// File: rtl/dicr_flag_eval.sv
module dicr_flag_eval
  import dicr_pkg::*;
(
  input  logic [REG_W-1:0] val_i,
  output logic             active_o
);
  logic any_flag;
  assign any_flag = |val_i[FLAG_LSB+MAX_CH-1:FLAG_LSB];
  assign active_o = (val_i[MASTER_BIT] & any_flag) | val_i[BUSERR_BIT];
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dicr_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic [31:0]       rd_data_o,
  output logic              irq_o
);
  logic [REG_W-1:0] reg_q, nxt_w;
  logic             active_w, irq_q;

  dicr_wr_merge #(.NUM_CH(NUM_CH)) u_merge (
    .cur_i     (reg_q),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .done_i    (done_i),
    .nxt_o     (nxt_w)
  );

  dicr_flag_eval u_eval (
    .val_i    (nxt_w),
    .active_o (active_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= '0;
      irq_q <= 1'b0;
    end else begin
      reg_q <= {active_w, nxt_w[SENT_BIT-1:0]};
      irq_q <= active_w & ~reg_q[SENT_BIT];
    end
  end

  assign rd_data_o = reg_q;
  assign irq_o     = irq_q;

  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[14:6] == '0);

  p_pulse_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_with_sent_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rd_data_o[SENT_BIT]);

  p_no_resend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[SENT_BIT] |=> !irq_o || !$past(rd_data_o[SENT_BIT]));

  p_idle_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && done_i == '0) |=> $stable(rd_data_o));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    p_flag_needs_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rd_data_o[FLAG_LSB+n]) |-> $past(done_i[n]));
  end
endmodule

// File: tb/dma_irq_ctrl_test.sv
`timescale 1ns/1ps
module dma_irq_ctrl_test;
  localparam int NCH = 7;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [31:0]     wr_data = '0;
  logic [NCH-1:0]  done = '0;
  logic [31:0]     rd_data;
  logic            irq;

  int n_checks = 0;
  int n_fails  = 0;

  // behavioural reference
  bit [31:0] m_reg = 0;
  bit        m_irq = 0;
  string     cur_tag = "R1";

  always #10 clk = ~clk;

  dma_irq_ctrl #(.NUM_CH(NCH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .done_i(done), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic compare();
    n_checks++;
    if (rd_data !== m_reg) begin
      n_fails++;
      $display("FAIL %s rd_data actual=%08h expected=%08h", cur_tag, rd_data, m_reg);
    end
    n_checks++;
    if (irq !== m_irq) begin
      n_fails++;
      $display("FAIL %s irq actual=%0b expected=%0b", cur_tag, irq, m_irq);
    end
  endtask

  // drive on falling edge, model one update, compare one clock later
  task automatic step(input bit w, input bit [31:0] d, input bit [NCH-1:0] dn, input string tag);
    bit [31:0] r;
    bit        act;
    wr_en = w; wr_data = d; done = dn;
    r = m_reg;
    if (w) begin
      r[5:0]   = d[5:0];
      r[15]    = d[15];
      r[23:16] = d[23:16];
      for (int i = 0; i < 7; i++) if (d[24+i]) r[24+i] = 0;
    end
    for (int i = 0; i < NCH; i++) if (dn[i] && r[16+i]) r[24+i] = 1;
    act = (r[23] && r[30:24] != 0) || r[15];
    m_irq = act && !m_reg[31];
    r[31] = act;
    m_reg = r;
    @(negedge clk);
    cur_tag = tag;
    compare();
  endtask

  initial begin
    #5_000_000;
    n_fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R1";
    compare(); // R1 reset state
    step(1, 32'hFFFF_FFFF, 0, "R2");
    step(0, 0, 0, "R6");
    step(1, 32'h0000_0000, 0, "R5");
    step(1, 32'h00FF_0000, 0, "R2");
    step(0, 0, 7'h01, "R4");
    step(0, 0, 0, "R6");
    step(0, 0, 7'h02, "R7");
    step(1, 32'h00FF_0000 | 32'h0100_0000, 0, "R3");
    step(1, 32'h02FF_0000, 0, "R5");
    step(0, 0, 7'h04, "R7");
    step(1, 32'h7FFF_0000, 0, "R3");
    step(1, 32'h0080_0000, 7'h7F, "R4");
    step(1, 32'h0000_8000, 0, "R5");
    step(0, 0, 0, "R6");
    step(1, 32'h0000_0000, 0, "R7");
    step(1, 32'h01FF_0000, 7'h01, "R4");
    step(1, 32'h0001_0000, 7'h01, "R4");
    for (int k = 0; k < 3000; k++) begin
      bit        w  = ($urandom % 4) == 0;
      bit [31:0] d  = $urandom;
      bit [NCH-1:0] dn = (($urandom % 3) == 0) ? NCH'($urandom) : '0;
      if ($urandom % 2) d[15] = 1'b0;
      step(w, d, dn, "R3");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule